// File: doc/BRIEF.md
# Level Interrupt Summary and Mask

This block gathers eleven level-sensitive interrupt request lines into one interrupt line for the CPU. The sources are the pins of two PCI slots, an Ethernet controller, a SCSI controller and the output of a cascaded legacy interrupt controller. Software reaches the block over a simple host I/O bus with an address, a read strobe, a write strobe and byte-wide data. The block has two byte registers at adjacent addresses, and together they form one 16-bit view in which the lower address holds the low byte. A write to a register loads the mask bits for its sources. A read returns the live request levels of those sources.

Each source is enabled when its mask bit is 0 and disabled when it is 1. The CPU output is the OR of every enabled request, passed through one register. Summary reads always show the raw request levels, whatever the mask holds, so software can poll a source it has disabled. Nothing is latched and nothing is cleared by a read. When the address matches neither register, the block ignores the access and does not drive the read data.

Top module: `irq_summary_unit`

## Requirements
- R1: While reset is asserted and after it is released, all eleven mask bits are 1. `cpu_irq_o` stays 0 until software clears a mask bit, even when every source is asserted.
- R2: A write to address 0x26 loads mask bits 7..0 from `wdata_i[7:0]`. A write to 0x27 loads mask bits 10..8 from `wdata_i[2:0]`, and the block ignores `wdata_i[7:3]`.
- R3: A mask bit of 1 disables its source and a 0 enables it. `cpu_irq_o` in each cycle equals the OR of `src_i & ~mask`, sampled at the previous rising clock edge.
- R4: While `rd_i` is high and `addr_i` is 0x26, `rdata_o` equals `src_i[7:0]` in the same cycle and `rdata_oe_o` is 1, whatever the mask holds.
- R5: While `rd_i` is high and `addr_i` is 0x27, `rdata_o[2:0]` equals `src_i[10:8]` and `rdata_o[7:3]` reads as 0, even after 1s have been written to those bits.
- R6: Summary bits follow the input levels. A bit stays 1 across repeated reads for as long as its line is high, and it reads 0 once the line drops.
- R7: An access to any other address, including 0x25, 0x28 and 0x126, leaves the mask unchanged and leaves `rdata_oe_o` and `rdata_o` at 0.
- R8: The source positions in `src_i` are as follows. SCSI is 7, Ethernet is 6 and the cascaded legacy controller is 5. Slot 0 uses 0 for INTA, 2 for INTB, 4 for INTC and 9 for INTD. Slot 1 uses 1 for INTA, 3 for INTB, 8 for INTC and 10 for INTD. Summary bit n is source n.
- R9: A read and a write to the same register in one cycle return the raw levels in that cycle, and the written mask still takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | I/O byte address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, mask loaded at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not driven |
| rdata_oe_o | output | 1 | Read data valid and driven |
| src_i | input | 11 | Level interrupt requests |
| cpu_irq_o | output | 1 | Registered combined interrupt to the CPU |

## Verification
Two functions can meet in one cycle: a summary read and a mask write to the same register. A third case is a mask write that lands in the same cycle as a change on a source line. The bench drives read and write together on 0x26 while the sources carry a pattern that differs from the written mask. It expects the raw pattern on `rdata_o` in that cycle and the new mask reflected on `cpu_irq_o` one edge later. A behavioural model, updated at every rising edge and compared at every falling edge, judges both outcomes.

// File: rtl/irq_summary_pkg.sv
package irq_summary_pkg;
  localparam int unsigned SRC_N  = 11;
  localparam int unsigned BYTE_W = 8;

  // source positions in the summary (R8)
  localparam int unsigned SRC_S0_INTA = 0;
  localparam int unsigned SRC_S1_INTA = 1;
  localparam int unsigned SRC_S0_INTB = 2;
  localparam int unsigned SRC_S1_INTB = 3;
  localparam int unsigned SRC_S0_INTC = 4;
  localparam int unsigned SRC_PIC     = 5;
  localparam int unsigned SRC_ETH     = 6;
  localparam int unsigned SRC_SCSI    = 7;
  localparam int unsigned SRC_S1_INTC = 8;
  localparam int unsigned SRC_S0_INTD = 9;
  localparam int unsigned SRC_S1_INTD = 10;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_REGS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0026
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [N_REGS-1:0] rd_sel_o,
  output logic [N_REGS-1:0] wr_sel_o
);
  logic [N_REGS-1:0] hit;

  for (genvar k = 0; k < N_REGS; k++) begin : g_hit
    assign hit[k] = (addr_i == BASE_ADDR + ADDR_W'(k));
  end

  assign rd_sel_o = hit & {N_REGS{rd_i}};
  assign wr_sel_o = hit & {N_REGS{wr_i}};
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned N_SRC  = 11,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_REGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REGS-1:0] wr_sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [N_SRC-1:0]  mask_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 mask_o[i] <= 1'b1;
      else if (wr_sel_i[i/BYTE_W]) mask_o[i] <= wdata_i[i%BYTE_W];
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned N_SRC  = 11,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_REGS = 2
) (
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_REGS-1:0] rd_sel_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  localparam int unsigned SUM_W = N_REGS * BYTE_W;

  logic [SUM_W-1:0] summary;

  if (SUM_W > N_SRC) begin : g_pad
    assign summary = {{(SUM_W-N_SRC){1'b0}}, src_i};
  end else begin : g_nopad
    assign summary = src_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_REGS; k++) begin
      if (rd_sel_i[k]) rdata_o = rdata_o | summary[k*BYTE_W +: BYTE_W];
    end
  end

  assign rdata_oe_o = |rd_sel_i;
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int unsigned N_SRC = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(src_i & ~mask_i);
  end
endmodule

// File: rtl/irq_summary_unit.sv
module irq_summary_unit #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_SRC  = irq_summary_pkg::SRC_N,
  parameter int unsigned BYTE_W = irq_summary_pkg::BYTE_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0026
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              cpu_irq_o
);
  localparam int unsigned N_REGS = (N_SRC + BYTE_W - 1) / BYTE_W;

  logic [N_REGS-1:0] rd_sel;
  logic [N_REGS-1:0] wr_sel;
  logic [N_SRC-1:0]  mask;

  irq_reg_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .rd_sel_o(rd_sel), .wr_sel_o(wr_sel)
  );

  irq_mask_bank #(.N_SRC(N_SRC), .BYTE_W(BYTE_W), .N_REGS(N_REGS)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_sel_i(wr_sel),
    .wdata_i(wdata_i), .mask_o(mask)
  );

  irq_read_mux #(.N_SRC(N_SRC), .BYTE_W(BYTE_W), .N_REGS(N_REGS)) u_rd (
    .src_i(src_i), .rd_sel_i(rd_sel),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  irq_out_reg #(.N_SRC(N_SRC)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .mask_i(mask), .irq_o(cpu_irq_o)
  );
endmodule

// File: rtl/irq_summary_chk.sv
module irq_summary_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_SRC  = 11,
  parameter int unsigned BYTE_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0026
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic [N_SRC-1:0]  src_i,
  input logic [N_SRC-1:0]  mask_q,
  input logic              cpu_irq_o
);
  localparam int unsigned SUM_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] LO_A = BASE_ADDR;
  localparam logic [ADDR_W-1:0] HI_A = BASE_ADDR + ADDR_W'(1);

  logic [SUM_W-1:0] sum_w;
  logic             hit;
  assign sum_w = SUM_W'(src_i);
  assign hit   = (addr_i == LO_A) || (addr_i == HI_A);

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_masked: assert (&mask_q);

  a_r3_irq_from_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o == $past(|(src_i & ~mask_q)));

  a_r2_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == LO_A) |=> mask_q[BYTE_W-1:0] == $past(wdata_i));

  a_r7_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && hit) |=> $stable(mask_q));

  a_r4_lo_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == LO_A) |-> (rdata_oe_o && rdata_o == sum_w[BYTE_W-1:0]));

  a_r5_hi_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == HI_A) |-> (rdata_oe_o && rdata_o == sum_w[SUM_W-1:BYTE_W]));

  a_r7_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && hit) |-> (!rdata_oe_o && rdata_o == '0));
endmodule

bind irq_summary_unit irq_summary_chk #(
  .ADDR_W(ADDR_W), .N_SRC(N_SRC), .BYTE_W(BYTE_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o),
  .src_i(src_i), .mask_q(mask), .cpu_irq_o(cpu_irq_o)
);

// File: tb/sim_irq_summary_unit.sv
module sim_irq_summary_unit;
  import irq_summary_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic [10:0] src = '0;
  logic        cpu_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_mask;
  int m_irq;

  always #4 clk = ~clk;

  irq_summary_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .src_i(src), .cpu_irq_o(cpu_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = 'h7FF;
      m_irq  = 0;
    end else begin
      m_irq = ((int'(src) & ~m_mask & 'h7FF) != 0) ? 1 : 0;
      if (wr && addr == 16'h0026)      m_mask = (m_mask & 'h700) | int'(wdata);
      else if (wr && addr == 16'h0027) m_mask = (m_mask & 'h0FF) | ((int'(wdata) & 7) << 8);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check("R3 cpu_irq", int'(cpu_irq), m_irq);
      if (rd && addr == 16'h0026) begin
        check("R4 lo read", int'(rdata), int'(src[7:0]));
        check("R4 lo oe", int'(rdata_oe), 1);
      end else if (rd && addr == 16'h0027) begin
        check("R5 hi read", int'(rdata), int'(src[10:8]));
        check("R5 hi oe", int'(rdata_oe), 1);
      end else begin
        check("R7 idle oe", int'(rdata_oe), 0);
        check("R7 idle data", int'(rdata), 0);
      end
    end
  end

  task automatic cyc(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; rd = r; wr = w; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(16'h0000, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #2 rst_ni = 1'b0;
    src = 11'h7FF;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    idle(2);
    @(negedge clk) check("R1 masked after reset", int'(cpu_irq), 0);

    cyc(16'h0026, 1, 0, 0);
    @(negedge clk) check("R4 raw lo with all masked", int'(rdata), 'hFF);
    cyc(16'h0027, 1, 0, 0);
    @(negedge clk) check("R5 raw hi", int'(rdata), 'h07);

    // unmask source 0 only
    src = '0;
    cyc(16'h0026, 0, 1, 8'hFE);
    idle(1);
    src = 11'h002;
    idle(2);
    @(negedge clk) check("R3 masked source", int'(cpu_irq), 0);
    src = 11'h001;
    idle(2);
    @(negedge clk) check("R3 enabled source", int'(cpu_irq), 1);

    // high register
    src = '0;
    cyc(16'h0027, 0, 1, 8'h03);
    src = 11'(1 << SRC_S0_INTD);
    idle(2);
    @(negedge clk) check("R2 hi bit1 masks INTD slot0", int'(cpu_irq), 0);
    src = 11'(1 << SRC_S1_INTD);
    idle(2);
    @(negedge clk) check("R2 hi bit2 enables INTD slot1", int'(cpu_irq), 1);
    src = '0;
    cyc(16'h0027, 0, 1, 8'hF8);
    cyc(16'h0027, 1, 0, 0);
    @(negedge clk) check("R5 reserved bits read zero", int'(rdata), 0);

    // other addresses
    cyc(16'h0025, 0, 1, 8'h00);
    cyc(16'h0028, 0, 1, 8'h00);
    cyc(16'h0126, 0, 1, 8'h00);
    src = 11'(1 << SRC_S1_INTB);
    idle(2);
    @(negedge clk) check("R7 stray writes ignored", int'(cpu_irq), 0);
    cyc(16'h0025, 1, 0, 0);
    @(negedge clk) check("R7 stray read undriven", int'(rdata_oe), 0);

    // level, no latch
    src = 11'(1 << SRC_ETH);
    cyc(16'h0026, 1, 0, 0);
    @(negedge clk) check("R6 first read", int'(rdata), 'h40);
    cyc(16'h0026, 1, 0, 0);
    @(negedge clk) check("R6 repeat read", int'(rdata), 'h40);
    src = '0;
    cyc(16'h0026, 1, 0, 0);
    @(negedge clk) check("R6 line dropped", int'(rdata), 0);

    // read and write together
    src = 11'h05A;
    cyc(16'h0026, 1, 1, 8'h00);
    @(negedge clk) check("R9 read during write", int'(rdata), 'h5A);
    idle(2);
    @(negedge clk) check("R9 write took effect", int'(cpu_irq), 1);

    // source positions
    src = 11'(1 << SRC_PIC);
    cyc(16'h0026, 1, 0, 0);
    @(negedge clk) check("R8 legacy controller bit5", int'(rdata), 'h20);
    src = 11'(1 << SRC_SCSI);
    cyc(16'h0026, 1, 0, 0);
    @(negedge clk) check("R8 scsi bit7", int'(rdata), 'h80);
    src = 11'(1 << SRC_S1_INTC);
    cyc(16'h0027, 1, 0, 0);
    @(negedge clk) check("R8 slot1 INTC hi bit0", int'(rdata), 'h01);
    src = 11'(1 << SRC_S1_INTD);
    cyc(16'h0027, 1, 0, 0);
    @(negedge clk) check("R8 slot1 INTD hi bit2", int'(rdata), 'h04);

    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule